// File: doc/BRIEF.md
# Cell-Framed Transmit Sink with Whole-Cell Flow Control

This block sits on the physical-layer side of a byte-wide cell transmit link. An ATM-layer master drives bytes, an active-low enable and a start-of-cell marker, all timed by the transmit byte clock. The block frames the bytes into fixed 53-byte cells (5 header bytes, then 48 payload bytes) and stores them in an internal two-cell buffer. It returns a cell-available flag to the master. That flag promises room for one complete cell, and it is changed only between cells.

A downstream consumer drains finished cells through a plain read port. It raises a read request, gets one byte per cycle one cycle later, and sees a start marker on the first byte of each cell. Framing faults are recovered locally. A start marker that arrives inside a cell throws away the partial cell, bumps a saturating runt counter and opens a new cell at that byte. Bytes that arrive while no cell is open are dropped.

Top module: `utopia_tx_sink`

## Requirements
- R1: After reset, txClav is 1, cellReady is 0, rdValid is 0 and runtCount is 0.
- R2: A byte is taken on a rising clock edge only when txEnbN is 0. Cycles with txEnbN at 1 are ignored whatever txData and txSoc show, and the byte position of an open cell is kept across them.
- R3: A cell is 53 bytes and opens with the byte that has txSoc at 1. The bytes are read out in arrival order, all 8 bits unchanged (bit 7 is the MSB).
- R4: Once a cell has been opened, txClav stays 1 until its 53rd byte has been taken.
- R5: The buffer holds two cells. When both slots are full, txClav is 0 from the cycle after the second cell completes. A start marker seen while txClav is 0 opens no cell, and that cell's bytes are discarded.
- R6: cellReady becomes 1 only after the 53rd byte of a cell has been written, and not earlier.
- R7: A start marker inside an open cell discards the partial cell and increments runtCount. The marked byte becomes byte 0 of a new cell.
- R8: Enabled bytes with txSoc at 0 that arrive while no cell is open are discarded.
- R9: With rdEn at 1 and cellReady at 1, the next oldest stored byte appears on rdData in the following cycle with rdValid at 1. rdSoc is 1 on byte 0 of each cell. Reading the 53rd byte frees the slot. With cellReady at 0, rdEn has no effect.
- R10: If the last byte of an incoming cell is written in the same cycle that the last byte of a stored cell is read, the stored cell count stays the same, and txClav and cellReady both stay 1.
- R11: runtCount saturates at its all-ones value (255 for the default 8-bit width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnbN | input | 1 | Active-low byte enable from the master |
| txData | input | 8 | Cell byte from the master |
| txSoc | input | 1 | Marks the first byte of a cell |
| txClav | output | 1 | Room for one full cell |
| rdEn | input | 1 | Read request from the consumer |
| rdData | output | 8 | Byte read from the buffer |
| rdSoc | output | 1 | rdData is byte 0 of a cell |
| rdValid | output | 1 | rdData and rdSoc are valid |
| cellReady | output | 1 | At least one complete cell is stored |
| runtCount | output | 8 | Saturating count of cells cut short |

## Verification
Two events can fall on the same clock edge: completing an incoming cell, which takes a slot, and reading the final byte of the oldest stored cell, which frees one. The bench sets this up by preloading one cell and then starting a 53-byte write and a 53-cycle read on the same falling edge, so that both final bytes land on one rising edge. It then expects txClav and cellReady to remain 1. The scoreboard must see the old cell followed by the new one, byte for byte.

// File: rtl/utx_pkg.sv
package utx_pkg;

  // Per-cycle strobes passed from the control unit to the datapath.
  typedef struct packed {
    logic wrEn;   // store txData at wrAddr
    logic rdEn;   // fetch the byte at rdAddr into the output register
  } bufStrobe_t;

  typedef enum logic {
    WR_IDLE = 1'b0,
    WR_FILL = 1'b1
  } wrState_t;

endpackage

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int SLOTS      = 2,
  parameter int RUNT_W     = 8,
  localparam int POS_W     = $clog2(CELL_BYTES),
  localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W     = $clog2(SLOTS + 1),
  localparam int ADDR_W    = $clog2(SLOTS * CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnbN,
  input  logic              txSoc,
  input  logic              rdEn,
  output logic              txClav,
  output logic              cellReady,
  output logic [RUNT_W-1:0] runtCount,
  output bufStrobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdFirst
);

  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(SLOTS);
  localparam logic [RUNT_W-1:0] RUNT_MAX  = {RUNT_W{1'b1}};

  wrState_t          wrState;
  logic [POS_W-1:0]  wrPos, rdPos, wrPosEff;
  logic [SLOT_W-1:0] wrSlot, rdSlot;
  logic [CNT_W-1:0]  cellCount, countNext;
  logic              clavQ;
  logic [RUNT_W-1:0] runtQ;

  logic byteIn, startCell, runtHit, fillByte, cellDone, rdGo, cellFreed;
  logic fillNext;

  // Write-side decode
  always_comb begin
    byteIn    = !txEnbN;
    startCell = byteIn && txSoc && ((wrState == WR_FILL) || clavQ);
    runtHit   = byteIn && txSoc && (wrState == WR_FILL);
    fillByte  = byteIn && !txSoc && (wrState == WR_FILL);
    cellDone  = fillByte && (wrPos == LAST_POS);
    wrPosEff  = startCell ? '0 : wrPos;
    fillNext  = startCell ? 1'b1 : (cellDone ? 1'b0 : (wrState == WR_FILL));
  end

  // Read-side decode
  always_comb begin
    rdGo      = rdEn && (cellCount != '0);
    cellFreed = rdGo && (rdPos == LAST_POS);
    countNext = cellCount + CNT_W'(cellDone) - CNT_W'(cellFreed);
  end

  always_comb begin
    strobe.wrEn = startCell || fillByte;
    strobe.rdEn = rdGo;
    wrAddr      = ADDR_W'(wrSlot) * ADDR_W'(CELL_BYTES) + ADDR_W'(wrPosEff);
    rdAddr      = ADDR_W'(rdSlot) * ADDR_W'(CELL_BYTES) + ADDR_W'(rdPos);
    rdFirst     = (rdPos == '0);
  end

  // Write framing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrState <= WR_IDLE;
      wrPos   <= '0;
      wrSlot  <= '0;
    end else begin
      wrState <= fillNext ? WR_FILL : WR_IDLE;
      if (startCell)
        wrPos <= POS_W'(1);
      else if (fillByte)
        wrPos <= cellDone ? '0 : wrPos + POS_W'(1);
      if (cellDone)
        wrSlot <= (wrSlot == LAST_SLOT) ? '0 : wrSlot + SLOT_W'(1);
    end
  end

  // Read sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPos  <= '0;
      rdSlot <= '0;
    end else if (rdGo) begin
      rdPos <= cellFreed ? '0 : rdPos + POS_W'(1);
      if (cellFreed)
        rdSlot <= (rdSlot == LAST_SLOT) ? '0 : rdSlot + SLOT_W'(1);
    end
  end

  // Occupancy, cell-available (boundary only) and runt counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellCount <= '0;
      clavQ     <= 1'b1;
      runtQ     <= '0;
    end else begin
      cellCount <= countNext;
      if (!fillNext)
        clavQ <= (countNext < FULL_CNT);
      if (runtHit && (runtQ != RUNT_MAX))
        runtQ <= runtQ + RUNT_W'(1);
    end
  end

  assign txClav    = clavQ;
  assign cellReady = (cellCount != '0);
  assign runtCount = runtQ;

  // R5: occupancy never exceeds the slot count
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cellCount <= FULL_CNT);

  // R5: a full buffer with no open cell withholds cell-available
  a_r5_clav_low_full: assert property (@(posedge clk) disable iff (!rstN)
    (cellCount == FULL_CNT && wrState == WR_IDLE) |-> !txClav);

  // R4: an open cell that is not finishing keeps cell-available up next cycle
  a_r4_clav_held: assert property (@(posedge clk) disable iff (!rstN)
    (wrState == WR_FILL && !cellDone) |=> txClav);

  // R6: a new stored cell appears only right after the last byte position
  a_r6_ready_after_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cellReady) |-> ($past(wrPos) == LAST_POS));

  // R7: a runt below saturation advances the counter by exactly one
  a_r7_runt_step: assert property (@(posedge clk) disable iff (!rstN)
    (runtHit && runtCount != RUNT_MAX) |=> (runtCount == $past(runtCount) + RUNT_W'(1)));

endmodule

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int SLOTS      = 2,
  localparam int DEPTH     = SLOTS * CELL_BYTES,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdFirst,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdSoc,
  output logic              rdValid
);

  logic [DATA_W-1:0] cellMem [DEPTH];
  logic [DATA_W-1:0] rdDataQ;
  logic              rdSocQ, rdValidQ;

  always_ff @(posedge clk) begin
    if (strobe.wrEn)
      cellMem[wrAddr] <= txData;
  end

  always_ff @(posedge clk) begin
    if (strobe.rdEn)
      rdDataQ <= cellMem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      rdSocQ   <= 1'b0;
    end else begin
      rdValidQ <= strobe.rdEn;
      rdSocQ   <= strobe.rdEn && rdFirst;
    end
  end

  assign rdData  = rdDataQ;
  assign rdSoc   = rdSocQ;
  assign rdValid = rdValidQ;

  // R9: every granted read produces a valid byte one cycle later
  a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> rdValid);

  // R3: addresses issued by the control stay inside the buffer
  a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn |-> (int'(wrAddr) < DEPTH)) and (strobe.rdEn |-> (int'(rdAddr) < DEPTH)));

endmodule

// File: rtl/utopia_tx_sink.sv
module utopia_tx_sink
  import utx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CELL_BYTES = 53,
  parameter int SLOTS      = 2,
  parameter int RUNT_W     = 8,
  localparam int ADDR_W    = $clog2(SLOTS * CELL_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnbN,
  input  logic [DATA_W-1:0] txData,
  input  logic              txSoc,
  output logic              txClav,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdSoc,
  output logic              rdValid,
  output logic              cellReady,
  output logic [RUNT_W-1:0] runtCount
);

  bufStrobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              rdFirst;

  utx_ctrl #(
    .CELL_BYTES(CELL_BYTES),
    .SLOTS     (SLOTS),
    .RUNT_W    (RUNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txEnbN   (txEnbN),
    .txSoc    (txSoc),
    .rdEn     (rdEn),
    .txClav   (txClav),
    .cellReady(cellReady),
    .runtCount(runtCount),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .rdFirst  (rdFirst)
  );

  utx_datapath #(
    .DATA_W    (DATA_W),
    .CELL_BYTES(CELL_BYTES),
    .SLOTS     (SLOTS)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .rdFirst(rdFirst),
    .txData (txData),
    .rdData (rdData),
    .rdSoc  (rdSoc),
    .rdValid(rdValid)
  );

endmodule

// File: tb/utopia_tx_sink_bench.sv
`timescale 1ns/1ps
module utopia_tx_sink_bench;

  localparam int CELL = 53;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnbN = 1'b1;
  logic [7:0] txData = '0;
  logic       txSoc = 1'b0;
  logic       txClav;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       rdSoc, rdValid, cellReady;
  logic [7:0] runtCount;

  int nChecks = 0;
  int nFail   = 0;
  logic [7:0] expData[$];
  logic       expSoc[$];

  always #5 clk = ~clk;

  utopia_tx_sink u_utopia_tx_sink (
    .clk(clk), .rstN(rstN), .txEnbN(txEnbN), .txData(txData), .txSoc(txSoc),
    .txClav(txClav), .rdEn(rdEn), .rdData(rdData), .rdSoc(rdSoc),
    .rdValid(rdValid), .cellReady(cellReady), .runtCount(runtCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cellByte(input int seed, input int i);
    return 8'((seed * 29 + i * 37) ^ 8'hA5);
  endfunction

  // Monitor: pops the scoreboard on every valid read byte (R3, R9)
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expData.size() == 0) begin
        check(1'b0, "R9 unexpected byte", int'(rdData), -1);
      end else begin
        logic [7:0] d;
        logic       s;
        d = expData.pop_front();
        s = expSoc.pop_front();
        check(rdData == d, "R3 data", int'(rdData), int'(d));
        check(rdSoc == s, "R9 rdSoc", int'(rdSoc), int'(s));
      end
    end
  end

  // Driver: one cell, optional enable gaps with junk on the bus (R2)
  task automatic sendCell(input int seed, input int gapEvery, input bit store,
                          input bit chkClav, input bit chkReady);
    for (int i = 0; i < CELL; i++) begin
      if (gapEvery > 0 && i > 0 && (i % gapEvery) == 0) begin
        for (int g = 0; g < 2; g++) begin
          @(negedge clk);
          txEnbN = 1'b1; txSoc = 1'b1; txData = 8'hFF;
        end
      end
      @(negedge clk);
      if (chkClav && i > 0) check(txClav == 1'b1, "R4 clav held", int'(txClav), 1);
      if (chkReady && i == CELL - 1) check(cellReady == 1'b0, "R6 not ready early", int'(cellReady), 0);
      txEnbN = 1'b0; txSoc = (i == 0); txData = cellByte(seed, i);
    end
    @(negedge clk);
    txEnbN = 1'b1; txSoc = 1'b0;
    if (store) begin
      for (int i = 0; i < CELL; i++) begin
        expData.push_back(cellByte(seed, i));
        expSoc.push_back(i == 0);
      end
    end
  endtask

  task automatic sendRaw(input int n, input bit soc, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      txEnbN = 1'b0; txSoc = soc || (i == 0 && seed >= 0); txData = cellByte(seed, i);
    end
    @(negedge clk);
    txEnbN = 1'b1; txSoc = 1'b0;
  endtask

  task automatic readCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdEn = 1'b1;
    end
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic finishRun();
    check(expData.size() == 0, "R9 scoreboard drained", expData.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(txClav == 1'b1, "R1 clav", int'(txClav), 1);
    check(cellReady == 1'b0, "R1 ready", int'(cellReady), 0);
    check(rdValid == 1'b0, "R1 valid", int'(rdValid), 0);
    check(runtCount == 8'd0, "R1 runt", int'(runtCount), 0);

    // R3 R4 R6: plain cell
    sendCell(1, 0, 1'b1, 1'b1, 1'b1);
    check(cellReady == 1'b1, "R6 ready after full", int'(cellReady), 1);
    readCycles(CELL);
    @(negedge clk);
    check(cellReady == 1'b0, "R9 slot freed", int'(cellReady), 0);

    // R2: gaps with junk on the bus
    sendCell(2, 5, 1'b1, 1'b1, 1'b0);
    check(runtCount == 8'd0, "R2 gap junk ignored", int'(runtCount), 0);
    readCycles(CELL);

    // R7: partial cell then new start marker
    sendRaw(20, 1'b0, 3);
    sendCell(4, 0, 1'b1, 1'b1, 1'b0);
    check(runtCount == 8'd1, "R7 runt counted", int'(runtCount), 1);
    readCycles(CELL);

    // R8: stray bytes with no open cell
    sendRaw(10, 1'b0, -1);
    check(cellReady == 1'b0, "R8 stray ignored", int'(cellReady), 0);
    sendCell(5, 0, 1'b1, 1'b1, 1'b0);
    readCycles(CELL);

    // R5: fill both slots, then a refused cell
    sendCell(6, 0, 1'b1, 1'b1, 1'b0);
    check(txClav == 1'b1, "R5 one slot left", int'(txClav), 1);
    sendCell(7, 0, 1'b1, 1'b1, 1'b0);
    check(txClav == 1'b0, "R5 clav low when full", int'(txClav), 0);
    sendCell(8, 0, 1'b0, 1'b0, 1'b0);
    check(runtCount == 8'd1, "R5 refused cell no runt", int'(runtCount), 1);
    readCycles(CELL);
    check(txClav == 1'b1, "R5 clav back after read", int'(txClav), 1);
    readCycles(CELL);
    @(negedge clk);
    check(cellReady == 1'b0, "R5 refused cell not stored", int'(cellReady), 0);

    // R9: read with empty buffer
    readCycles(3);
    check(rdValid == 1'b0, "R9 empty read ignored", int'(rdValid), 0);

    // R10: completion and release on the same edge
    sendCell(9, 0, 1'b1, 1'b1, 1'b0);
    fork
      sendCell(10, 0, 1'b1, 1'b1, 1'b0);
      readCycles(CELL);
    join
    check(txClav == 1'b1, "R10 clav kept", int'(txClav), 1);
    check(cellReady == 1'b1, "R10 ready kept", int'(cellReady), 1);
    readCycles(CELL);
    @(negedge clk);
    check(cellReady == 1'b0, "R10 single cell left", int'(cellReady), 0);

    // R11: runt saturation
    sendRaw(300, 1'b1, 11);
    check(runtCount == 8'd255, "R11 saturated", int'(runtCount), 255);
    sendCell(12, 0, 1'b1, 1'b1, 1'b0);
    check(runtCount == 8'd255, "R11 stays saturated", int'(runtCount), 255);
    readCycles(CELL);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule